// File: doc/BRIEF.md
# Lane-wise Vector Minimum/Maximum Unit

The unit takes a 32-bit vector instruction word, two 128-bit operands and a valid strobe. It checks whether the word encodes a three-register minimum or maximum operation. If it does, the unit splits both operands into lanes of 8, 16, 32 or 64 bits. For each lane it picks the smaller or the larger element, comparing as either signed or unsigned. The result is registered and comes out one cycle after the strobe, together with a one-cycle valid pulse.

A half-width form works only on the low 64 bits and returns zero in the upper half. The combination of 64-bit lanes with the half-width form has no meaning. When that combination is strobed, the unit raises an illegal-operation pulse and produces no result. A word that is not a min/max operation is ignored.

The register-number fields are left to the surrounding register-file logic and have no effect here.

Top module: `vec_minmax_unit`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `illegal_op` and `result` are all zero.
- R2: A word is accepted only when bit 31 is 0, bits 28:24 are 01110, bit 21 is 1, and bits 15:10 ANDed with 111101 equal 011001. A strobe with any other word raises neither `out_valid` nor `illegal_op` in the next cycle, and `result` keeps its previous value.
- R3: Bits 15:10 equal to 011001 (bit 11 = 0) select the per-lane maximum. Bits 15:10 equal to 011011 (bit 11 = 1) select the per-lane minimum.
- R4: Bit 29 = 1 compares lanes as unsigned integers. Bit 29 = 0 compares them as two's-complement signed integers.
- R5: Bits 23:22 select the lane width as 8 << size. Size 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies operand bits [i*W +: W].
- R6: When bit 30 is 0, `result[127:64]` is zero. The low half still holds the per-lane result of the low 64 bits of the operands.
- R7: An accepted word with size 3 and bit 30 = 0 produces a one-cycle `illegal_op` pulse in the next cycle. It raises no `out_valid`, and `result` is unchanged.
- R8: A strobe with a legal word gives `out_valid` high exactly in the following cycle, with `result` valid in that same cycle. The pulse lasts one cycle for each strobe.
- R9: The register-number fields (bits 20:16, 9:5 and 4:0) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe qualifying the instruction word and the operands |
| insn | input | 32 | Instruction word |
| opa | input | 128 | First operand |
| opb | input | 128 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after an accepted legal strobe |
| result | output | 128 | Registered per-lane min/max result |
| illegal_op | output | 1 | Pulse for an accepted word with 64-bit lanes in half-width form |

## Verification
Every combination of lane size, signedness, min/max and width form is swept over fixed and random operand patterns.

- 0x80 lanes against 0x7F lanes separate signed from unsigned comparison.
- All-ones against zero separates minimum from maximum.
- Equal operands show that a tie returns that value.
- Random operands expose lane-boundary mistakes, because the sign bit of each lane width sits in a different place.

Beyond the sweep, several patterns are aimed at single requirements:

- Words with one fixed opcode bit flipped must leave every output untouched.
- The 64-bit half-width word must give only the illegal pulse.
- Identical operands under different register fields must give identical results.

// File: rtl/vmm_pkg.sv
// Package: shared widths and the decoded-operation record for the vector
// min/max unit. Assumes a 32-bit instruction word and a 128-bit datapath.
package vmm_pkg;
    localparam int INSN_W  = 32;
    localparam int DATA_W  = 128;
    localparam int HALF_W  = DATA_W / 2;
    localparam int N_SIZES = 4;

    typedef struct packed {
        logic       hit;      // word encodes a min/max operation
        logic       illegal;  // 64-bit lanes requested in half-width form
        logic       is_min;   // 1: minimum, 0: maximum
        logic       is_uns;   // 1: unsigned compare
        logic [1:0] size;     // lane width = 8 << size
        logic       full;     // 1: full 128-bit form
    } vmm_op_t;
endpackage

// File: rtl/vmm_decode.sv
// Module: vmm_decode
// Purely combinational decode of the instruction word into a vmm_op_t.
// Assumes fields at fixed positions; register numbers are not used here.
module vmm_decode
    import vmm_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output vmm_op_t           op
);
    localparam logic [4:0] CLASS_BITS = 5'b01110;
    localparam logic [5:0] OPC_MASK   = 6'b111101;
    localparam logic [5:0] OPC_VALUE  = 6'b011001;

    logic unused_regfields;
    assign unused_regfields = ^{insn[20:16], insn[9:0]};

    // Field match and per-field extraction.
    always_comb begin
        op.hit     = (insn[31] == 1'b0) && (insn[28:24] == CLASS_BITS)
                  && (insn[21] == 1'b1)
                  && ((insn[15:10] & OPC_MASK) == OPC_VALUE);
        op.full    = insn[30];
        op.is_uns  = insn[29];
        op.size    = insn[23:22];
        op.is_min  = insn[11];
        op.illegal = (insn[23:22] == 2'd3) && !insn[30];
    end
endmodule

// File: rtl/vmm_lane_alu.sv
// Module: vmm_lane_alu
// Per-lane min/max over a DATA_W vector split into LANE_W lanes.
// Assumes DATA_W is a whole multiple of LANE_W. Combinational.
module vmm_lane_alu #(
    parameter int DATA_W = 128,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_min,
    input  logic              is_uns,
    output logic [DATA_W-1:0] y
);
    localparam int N_LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] la, lb;
        logic              a_less;
        assign la = a[i*LANE_W +: LANE_W];
        assign lb = b[i*LANE_W +: LANE_W];
        // Compare one lane and choose the selected element.
        always_comb begin
            a_less = is_uns ? (la < lb) : ($signed(la) < $signed(lb));
            y[i*LANE_W +: LANE_W] = (a_less == is_min) ? la : lb;
        end
    end
endmodule

// File: rtl/vec_minmax_unit.sv
// Module: vec_minmax_unit (top)
// Decodes a vector min/max word, computes all lane widths in parallel,
// selects by size, clears the upper half for the half-width form and
// registers the result. Assumes one operation per strobe and no back-pressure.
module vec_minmax_unit
    import vmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);
    vmm_op_t           op;
    logic [DATA_W-1:0] by_size [N_SIZES];
    logic [DATA_W-1:0] next_res;
    logic              fire, bad;

    vmm_decode u_dec (.insn(insn), .op(op));

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        vmm_lane_alu #(.DATA_W(DATA_W), .LANE_W(8 << s)) u_alu (
            .a(opa), .b(opb), .is_min(op.is_min), .is_uns(op.is_uns),
            .y(by_size[s])
        );
    end

    // Select the lane-width variant and clear the upper half if needed.
    always_comb begin
        next_res = by_size[op.size];
        if (!op.full) next_res[DATA_W-1:HALF_W] = '0;
        fire = in_valid && op.hit && !op.illegal;
        bad  = in_valid && op.hit && op.illegal;
    end

    // Output register: result held until the next legal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            illegal_op <= 1'b0;
            result     <= '0;
        end else begin
            out_valid  <= fire;
            illegal_op <= bad;
            if (fire) result <= next_res;
        end
    end
endmodule

// File: rtl/vmm_checker.sv
// Module: vmm_checker
// Temporal checks on the ports of vec_minmax_unit; bound to every instance.
module vmm_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [31:0]  insn,
    input logic [63:0]  opa_lo,
    input logic [63:0]  opb_lo,
    input logic         out_valid,
    input logic [127:0] result,
    input logic         illegal_op
);
    logic unused_chk;
    assign unused_chk = ^{insn[20:16], insn[9:0]};

    logic is_op, is_bad, is_legal, u64max, u64min;
    assign is_op    = !insn[31] && insn[28:24] == 5'b01110 && insn[21]
                   && insn[15:12] == 4'b0110 && insn[10];
    assign is_bad   = is_op && insn[23:22] == 2'd3 && !insn[30];
    assign is_legal = is_op && !is_bad;
    assign u64max   = is_legal && insn[23:22] == 2'd3 && insn[29] && !insn[11];
    assign u64min   = is_legal && insn[23:22] == 2'd3 && insn[29] && insn[11];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !illegal_op && result == '0);            // R1
    AST_NOMATCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !is_op |=> !out_valid && !illegal_op && $stable(result)); // R2
    AST_UMAX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && u64max |=> result[63:0] >= $past(opa_lo)
                            && result[63:0] >= $past(opb_lo));             // R3
    AST_UMIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && u64min |=> result[63:0] <= $past(opa_lo)
                            && result[63:0] <= $past(opb_lo));             // R4
    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_legal && !insn[30] |=> result[127:64] == '0);       // R6
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_bad |=> illegal_op && !out_valid && $stable(result)); // R7
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_legal |=> out_valid && !illegal_op);                // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !illegal_op);                          // R8
endmodule

bind vec_minmax_unit vmm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .opa_lo(opa[63:0]), .opb_lo(opb[63:0]), .out_valid(out_valid),
    .result(result), .illegal_op(illegal_op)
);

// File: tb/sim_vec_minmax_unit.sv
module sim_vec_minmax_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] opa = '0, opb = '0;
    logic         out_valid, illegal_op;
    logic [127:0] result;
    int tests = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vec_minmax_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .insn(insn), .opa(opa), .opb(opb), .out_valid(out_valid),
        .result(result), .illegal_op(illegal_op));

    function automatic logic [31:0] mk(input bit q, input bit u,
            input logic [1:0] sz, input bit mn, input logic [14:0] regs);
        return {1'b0, q, u, 5'b01110, sz, 1'b1, regs[14:10],
                3'b011, 1'b0, mn, 1'b1, regs[9:0]};
    endfunction

    // Expected value from the requirements: signed order by flipping the sign bit.
    function automatic logic [127:0] model(input logic [31:0] w,
            input logic [127:0] a, input logic [127:0] b);
        int lw, n;
        logic [63:0] m, la, lb, ka, kb, pick;
        logic [127:0] r;
        lw = 8 << w[23:22];
        n  = 128 / lw;
        m  = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
        r  = '0;
        for (int i = 0; i < n; i++) begin
            la = 64'(a >> (i*lw)) & m;
            lb = 64'(b >> (i*lw)) & m;
            ka = w[29] ? la : la ^ (64'd1 << (lw-1));
            kb = w[29] ? lb : lb ^ (64'd1 << (lw-1));
            if (w[11]) pick = (ka < kb) ? la : lb;
            else       pick = (ka > kb) ? la : lb;
            r = r | ({64'd0, pick} << (i*lw));
        end
        if (!w[30]) r[127:64] = '0;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [31:0] w, input logic [127:0] a,
                          input logic [127:0] b);
        @(negedge clk);
        insn = w; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input logic [31:0] w, input logic [127:0] a,
                       input logic [127:0] b, input string tag);
        logic [127:0] e;
        e = model(w, a, b);
        strobe(w, a, b);
        chk(out_valid && !illegal_op && result == e, tag, result, e);
    endtask

    task automatic run_silent(input logic [31:0] w, input string tag);
        logic [127:0] prev;
        prev = result;
        strobe(w, ~prev, {128{1'b1}});
        chk(!out_valid && !illegal_op && result == prev, tag,
            {out_valid, illegal_op, result[125:0]}, {2'b00, prev[125:0]});
    endtask

    task automatic run_illegal(input logic [31:0] w, input string tag);
        logic [127:0] prev;
        prev = result;
        strobe(w, {128{1'b1}}, '0);
        chk(illegal_op && !out_valid && result == prev, tag,
            {out_valid, illegal_op, result[125:0]}, {2'b01, prev[125:0]});
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] pa [6];
        logic [127:0] pb [6];
        logic [127:0] r1;
        logic [31:0]  w;
        repeat (3) @(negedge clk);
        chk(!out_valid && !illegal_op && result == '0, "R1",
            {out_valid, illegal_op, result[125:0]}, '0);
        rst_n = 1'b1;

        pa[0] = {16{8'h80}};        pb[0] = {16{8'h7F}};
        pa[1] = '0;                 pb[1] = {128{1'b1}};
        pa[2] = {16{8'h55}};        pb[2] = {16{8'hAA}};
        pa[3] = {4{32'h1234_5678}}; pb[3] = pa[3];
        pa[4] = {$urandom, $urandom, $urandom, $urandom};
        pb[4] = {$urandom, $urandom, $urandom, $urandom};
        pa[5] = {$urandom, $urandom, $urandom, $urandom};
        pb[5] = {$urandom, $urandom, $urandom, $urandom};

        // Sweep every size, signedness, min/max and width form (R5, R6).
        for (int q = 0; q < 2; q++)
            for (int sz = 0; sz < 4; sz++)
                for (int u = 0; u < 2; u++)
                    for (int mn = 0; mn < 2; mn++) begin
                        w = mk(q[0], u[0], sz[1:0], mn[0], 15'($urandom));
                        if (sz == 3 && q == 0) run_illegal(w, "R7");
                        else
                            for (int p = 0; p < 6; p++)
                                run(w, pa[p], pb[p], q == 0 ? "R6" : "R5");
                    end

        // Max versus min on one pattern: 0x01 lanes against 0xFE lanes, unsigned.
        run(mk(1, 1, 0, 0, 0), {16{8'h01}}, {16{8'hFE}}, "R3");
        chk(result == {16{8'hFE}}, "R3", result, {16{8'hFE}});
        run(mk(1, 1, 0, 1, 0), {16{8'h01}}, {16{8'hFE}}, "R3");
        chk(result == {16{8'h01}}, "R3", result, {16{8'h01}});

        // Signed versus unsigned at 16 bits: 0x8000 is below 0x0001 only when signed.
        run(mk(1, 0, 1, 1, 0), {8{16'h8000}}, {8{16'h0001}}, "R4");
        chk(result == {8{16'h8000}}, "R4", result, {8{16'h8000}});
        run(mk(1, 1, 1, 1, 0), {8{16'h8000}}, {8{16'h0001}}, "R4");
        chk(result == {8{16'h0001}}, "R4", result, {8{16'h0001}});

        // Half-width form: the upper half is zero even when both upper halves are all ones.
        run(mk(0, 1, 2, 0, 0), {128{1'b1}}, {128{1'b1}}, "R6");
        chk(result[127:64] == '0, "R6", result, {64'd0, {64{1'b1}}});

        // Single-bit corruptions of the fixed fields must be ignored (R2).
        w = mk(1, 0, 0, 0, 0);
        run_silent(w ^ 32'h8000_0000, "R2");
        run_silent(w ^ 32'h0100_0000, "R2");
        run_silent(w ^ 32'h0800_0000, "R2");
        run_silent(w ^ 32'h0020_0000, "R2");
        run_silent(w ^ 32'h0000_8000, "R2");
        run_silent(w ^ 32'h0000_1000, "R2");
        run_silent(w ^ 32'h0000_0400, "R2");
        run_silent(w ^ 32'h0000_4000, "R2");

        // The illegal form leaves the result alone (R7).
        run(mk(1, 0, 3, 0, 0), pa[4], pb[4], "R7");
        run_illegal(mk(0, 1, 3, 1, 15'h7FFF), "R7");

        // out_valid lasts a single cycle (R8).
        run(mk(1, 0, 2, 0, 0), pa[5], pb[5], "R8");
        @(negedge clk);
        chk(!out_valid, "R8", {127'd0, out_valid}, '0);

        // Register fields have no effect (R9).
        run(mk(1, 0, 1, 0, 15'h0000), pa[4], pb[5], "R9");
        r1 = result;
        run(mk(1, 0, 1, 0, 15'h7FFF), pa[4], pb[5], "R9");
        chk(result == r1, "R9", result, r1);
        run(mk(1, 0, 1, 0, 15'h2A55), pa[4], pb[5], "R9");
        chk(result == r1, "R9", result, r1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule